// File: doc/BRIEF.md
# Mixed-Sign Byte Matrix Multiply-Accumulate Unit

This datapath unit takes two 128-bit source vectors and a 128-bit accumulator vector. It computes a small integer matrix product and adds it into the accumulator. The first source is read as a 2-row by 8-column matrix of bytes. The second source is read as an 8-row by 2-column matrix of bytes. The product is a 2x2 tile of 32-bit lanes. Each lane is an 8-way byte dot product added to the matching accumulator lane. The updated tile is returned as a new 128-bit vector, which replaces the old accumulator in the caller's storage. No flags or status are produced.

Two mode inputs choose how each source's bytes are read: unsigned or two's-complement. The usual operating point is the mixed-sign mode, with the first source unsigned (`a_is_signed` = 0) and the second source signed (`b_is_signed` = 1). All four combinations are supported.

Operands enter through a valid/ready handshake. The result leaves through a registered valid/ready output stage, one cycle after acceptance. The input side is stalled while an unconsumed result is held.

Top module: `mixsign_mmla_unit`

## Requirements
- R1: Row i of the first matrix is bytes 8i..8i+7 of `src_a`. Column j of the second matrix is bytes 8j..8j+7 of `src_b`. Byte 0 is bits 7:0, and dot-product term k pairs byte 8i+k of `src_a` with byte 8j+k of `src_b`.
- R2: Result lane 2i+j holds tile element (i,j). Lane n occupies bits 32n+31:32n of `result` and adds to bits 32n+31:32n of `acc_in`.
- R3: With `a_is_signed` = 0, each `src_a` byte counts as 0..255. With `a_is_signed` = 1, each `src_a` byte counts as two's complement, -128..127.
- R4: With `b_is_signed` = 1, each `src_b` byte counts as two's complement. With `b_is_signed` = 0, each `src_b` byte counts as 0..255.
- R5: Each result lane equals the accumulator lane plus the sum of its eight byte products, wrapped modulo 2^32 with no saturation.
- R6: An input is accepted on a rising edge where `in_valid` and `in_ready` are both high. `out_valid` is then high after that same edge, with `result` holding the value computed from that input.
- R7: While `out_valid` is high and `out_ready` is low:
  - `in_ready` is low;
  - `out_valid` and `result` keep their values;
  - offered inputs are not taken.
- R8: `in_ready` is high whenever `out_valid` is low or `out_ready` is high, so that one operation per cycle can be streamed.
- R9: After reset, `out_valid` is low and `in_ready` is high.
- R10: When a result is taken (`out_valid` and `out_ready` high) and no new input is accepted on that edge, `out_valid` is low after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands offered |
| in_ready | output | 1 | Unit can take operands this cycle |
| src_a | input | 128 | First source, 2x8 byte matrix (rows are byte groups) |
| src_b | input | 128 | Second source, 8x2 byte matrix (columns are byte groups) |
| acc_in | input | 128 | Accumulator tile, four 32-bit lanes |
| a_is_signed | input | 1 | 1: read `src_a` bytes as signed |
| b_is_signed | input | 1 | 1: read `src_b` bytes as signed |
| out_valid | output | 1 | Result held and offered |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 128 | Updated accumulator tile |

## Verification
Every result is due exactly one rising edge after the edge that accepted its operands. While the consumer withholds `out_ready`, that result must stay unchanged for as many cycles as the stall lasts. The bench drives inputs and samples outputs at the falling edge. After each falling edge it updates a behavioural model with the handshake outcome of the coming rising edge. That way the next sample is compared against exactly the value due one register later. `in_ready` is checked a short delay after `out_ready` is driven, since it depends on it within the same cycle.

// File: rtl/mmla_pkg.sv
package mmla_pkg;
  localparam int BYTE_W = 8;
  localparam int EXT_W  = BYTE_W + 1;
  localparam int PROD_W = 2 * EXT_W;

  // Widen one byte to a signed value per the mode bit.
  function automatic logic signed [EXT_W-1:0] widen(input logic [BYTE_W-1:0] v,
                                                    input logic is_signed);
    return is_signed ? $signed({v[BYTE_W-1], v}) : $signed({1'b0, v});
  endfunction

  // Product of two mode-qualified bytes, exact in PROD_W bits.
  function automatic logic signed [PROD_W-1:0] byte_mul(input logic [BYTE_W-1:0] x,
                                                        input logic x_signed,
                                                        input logic [BYTE_W-1:0] y,
                                                        input logic y_signed);
    logic signed [PROD_W-1:0] xe, ye;
    xe = PROD_W'(widen(x, x_signed));
    ye = PROD_W'(widen(y, y_signed));
    return xe * ye;
  endfunction
endpackage

// File: rtl/mmla_dot_lane.sv
module mmla_dot_lane
  import mmla_pkg::*;
#(
  parameter int TERMS  = 8,
  parameter int LANE_W = 32
) (
  input  logic [TERMS*BYTE_W-1:0] row_bytes,
  input  logic [TERMS*BYTE_W-1:0] col_bytes,
  input  logic                    row_signed,
  input  logic                    col_signed,
  input  logic [LANE_W-1:0]       acc_lane,
  output logic [LANE_W-1:0]       sum_lane
);
  localparam int SUM_W = PROD_W + $clog2(TERMS) + 1;

  logic signed [SUM_W-1:0]  dot_sum;
  logic signed [LANE_W-1:0] dot_ext;

  always_comb begin
    dot_sum = '0;
    for (int k = 0; k < TERMS; k++) begin
      dot_sum = dot_sum + SUM_W'(byte_mul(row_bytes[k*BYTE_W +: BYTE_W], row_signed,
                                          col_bytes[k*BYTE_W +: BYTE_W], col_signed));
    end
    dot_ext  = LANE_W'(dot_sum);
    sum_lane = acc_lane + dot_ext;
  end
endmodule

// File: rtl/mmla_out_stage.sv
module mmla_out_stage #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         drain,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      q     <= '0;
    end else if (load) begin
      valid <= 1'b1;
      q     <= d;
    end else if (drain) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mixsign_mmla_unit.sv
module mixsign_mmla_unit
  import mmla_pkg::*;
#(
  parameter int ROWS   = 2,
  parameter int COLS   = 2,
  parameter int DEPTH  = 8,
  parameter int LANE_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic [ROWS*DEPTH*BYTE_W-1:0]     src_a,
  input  logic [COLS*DEPTH*BYTE_W-1:0]     src_b,
  input  logic [ROWS*COLS*LANE_W-1:0]      acc_in,
  input  logic                             a_is_signed,
  input  logic                             b_is_signed,
  output logic                             out_valid,
  input  logic                             out_ready,
  output logic [ROWS*COLS*LANE_W-1:0]      result
);
  localparam int GROUP_W = DEPTH * BYTE_W;
  localparam int TILE_W  = ROWS * COLS * LANE_W;

  // Named events for the checker.
  logic              in_fire;
  logic              out_fire;
  logic [TILE_W-1:0] next_result;

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    for (genvar j = 0; j < COLS; j++) begin : g_col
      localparam int LANE = i * COLS + j;
      mmla_dot_lane #(
        .TERMS (DEPTH),
        .LANE_W(LANE_W)
      ) u_lane (
        .row_bytes (src_a[i*GROUP_W +: GROUP_W]),
        .col_bytes (src_b[j*GROUP_W +: GROUP_W]),
        .row_signed(a_is_signed),
        .col_signed(b_is_signed),
        .acc_lane  (acc_in[LANE*LANE_W +: LANE_W]),
        .sum_lane  (next_result[LANE*LANE_W +: LANE_W])
      );
    end
  end

  mmla_out_stage #(.W(TILE_W)) u_out (
    .clk  (clk),
    .rst_n(rst_n),
    .load (in_fire),
    .drain(out_fire),
    .d    (next_result),
    .q    (result),
    .valid(out_valid)
  );
endmodule

// File: rtl/mmla_checker.sv
module mmla_checker #(
  parameter int W = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_fire,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] result,
  input logic [W-1:0] next_result
);
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_valid);

  a_r5_captured: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> result == $past(next_result));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result)));

  a_r7_block: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r8_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready);

  a_r10_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

bind mixsign_mmla_unit mmla_checker #(.W(TILE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_fire    (in_fire),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .result     (result),
  .next_result(next_result)
);

// File: tb/sim_mixsign_mmla_unit.sv
module sim_mixsign_mmla_unit;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] src_a = '0;
  logic [127:0] src_b = '0;
  logic [127:0] acc_in = '0;
  logic         a_is_signed = 1'b0;
  logic         b_is_signed = 1'b1;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] result;

  always #(CLK_PERIOD/2) clk = ~clk;

  mixsign_mmla_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
    .a_is_signed(a_is_signed), .b_is_signed(b_is_signed),
    .out_valid(out_valid), .out_ready(out_ready), .result(result)
  );

  int           checks = 0;
  int           fails = 0;
  bit           done = 1'b0;
  logic         exp_valid = 1'b0;
  logic [127:0] exp_res = '0;
  string        vtag = "R9";
  string        rtag = "R5";

  // Behavioural reference: plain integer arithmetic wraps at 32 bits.
  function automatic logic [127:0] model(logic [127:0] a, logic [127:0] b,
                                         logic [127:0] acc, logic as, logic bs);
    logic [127:0] r;
    for (int row = 0; row < 2; row++) begin
      for (int col = 0; col < 2; col++) begin
        int s;
        s = int'(acc[(row*2+col)*32 +: 32]);
        for (int k = 0; k < 8; k++) begin
          int x;
          int y;
          x = as ? int'($signed(a[(row*8+k)*8 +: 8])) : int'({24'd0, a[(row*8+k)*8 +: 8]});
          y = bs ? int'($signed(b[(col*8+k)*8 +: 8])) : int'({24'd0, b[(col*8+k)*8 +: 8]});
          s = s + x * y;
        end
        r[(row*2+col)*32 +: 32] = s;
      end
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(string tag, logic v, logic [127:0] a, logic [127:0] b,
                       logic [127:0] acc, logic as, logic bs, logic ordy);
    @(negedge clk);
    chk(vtag, {127'd0, out_valid}, {127'd0, exp_valid});
    if (exp_valid) chk(rtag, result, exp_res);
    in_valid = v; src_a = a; src_b = b; acc_in = acc;
    a_is_signed = as; b_is_signed = bs; out_ready = ordy;
    #1;
    chk((exp_valid && !ordy) ? "R7" : "R8", {127'd0, in_ready},
        {127'd0, (!exp_valid || ordy)});
    if (v && (!exp_valid || ordy)) begin
      exp_valid = 1'b1; exp_res = model(a, b, acc, as, bs); rtag = tag; vtag = "R6";
    end else if (exp_valid && ordy) begin
      exp_valid = 1'b0; vtag = "R10";
    end else if (exp_valid) begin
      vtag = "R7"; rtag = "R7";
    end
  endtask

  function automatic logic [127:0] rep(logic [7:0] v);
    return {16{v}};
  endfunction

  initial begin
    logic [127:0] ramp;
    for (int k = 0; k < 16; k++) ramp[k*8 +: 8] = 8'(k + 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9: state straight after reset
    chk("R9", {127'd0, out_valid}, 128'd0);
    chk("R9", {127'd0, in_ready}, 128'd1);
    // R2: zero operands return accumulator lanes in place
    cycle("R2", 1, '0, '0, {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111}, 0, 1, 1);
    // R1: byte ordering of rows and columns
    cycle("R1", 1, ramp, {64'h0, 64'h0000_0001_0000_0000}, '0, 0, 1, 1);
    cycle("R1", 1, ramp, {64'h0100_0000_0000_0000, 64'h0}, '0, 0, 1, 1);
    cycle("R1", 1, ramp, {8'hF9, 8'h05, 112'h0, 8'h02}, '0, 0, 1, 1);
    // R3: first source sign modes
    cycle("R3", 1, rep(8'hFF), rep(8'h01), '0, 0, 1, 1);
    cycle("R3", 1, rep(8'hFF), rep(8'h01), '0, 1, 1, 1);
    // R4: second source sign modes
    cycle("R4", 1, rep(8'h01), rep(8'hFF), '0, 0, 1, 1);
    cycle("R4", 1, rep(8'h01), rep(8'hFF), '0, 0, 0, 1);
    cycle("R4", 1, rep(8'h80), rep(8'h80), '0, 1, 0, 1);
    // R5: extreme products and modulo wrap
    cycle("R5", 1, rep(8'hFF), rep(8'h80), {4{32'h00000005}}, 0, 1, 1);
    cycle("R5", 1, rep(8'hFF), rep(8'h7F), {4{32'h7FFFFFFF}}, 0, 1, 1);
    cycle("R5", 1, rep(8'hFF), rep(8'h80), {4{32'h80000000}}, 0, 1, 1);
    // R10: result drains with no new input
    cycle("R10", 0, '0, '0, '0, 0, 1, 1);
    cycle("R10", 0, '0, '0, '0, 0, 1, 1);
    // R7: stall with new operands offered
    cycle("R7", 1, ramp, ramp, {4{32'h12345678}}, 0, 1, 0);
    for (int n = 0; n < 4; n++) cycle("R7", 1, rep(8'h33), rep(8'h44), '0, 0, 1, 0);
    cycle("R7", 0, '0, '0, '0, 0, 1, 1);
    // R8: back-to-back stream
    for (int n = 0; n < 8; n++)
      cycle("R8", 1, {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom}, 0, 1, 1);
    // Random traffic, all mode combinations and random back-pressure
    for (int n = 0; n < 400; n++) begin
      logic [1:0] m;
      m = 2'($urandom);
      cycle("R5", 1'($urandom), {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom}, m[0], m[1], 1'($urandom));
    end
    cycle("R10", 0, '0, '0, '0, 0, 1, 1);
    cycle("R10", 0, '0, '0, '0, 0, 1, 1);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule